// File: doc/BRIEF.md
# SD Card Clock Generator

This block produces the card clock of an SD host controller from two free-running sources. One is a fast base clock. The other is the output of an external clock multiplier. Software drives it through one 16-bit control word. That word holds an internal-clock enable, a read-only stable flag, a card-clock enable, a law select and a 10-bit divisor `N`. Under the even law the base clock is divided by `2·N`, and `N = 0` passes the base clock straight through. Under the integer law the multiplied clock is divided by `N + 1`, which reaches every divisor from 1 to 1024.

Software first sets the internal-clock enable. It then polls the stable flag, which rises a fixed number of base cycles later. Only then does a card-clock enable actually open the output gate. The output passes through a level-sensitive gate that can only change while the raw divided clock is low, so the gate never clips a pulse.

The sequencer has four states:
- **OFF**: the internal clock is disabled.
- **WARM**: the stable count is in progress.
- **READY**: the clock is stable and the card clock is closed.
- **RUN**: the card clock is open.

Its transitions are:
- OFF→WARM when the enable is set.
- WARM→READY when the count expires.
- READY→RUN when the card enable is set and the applied law matches the requested law.
- RUN→READY when the card enable is cleared.
- Any state→OFF when the internal-clock enable is cleared.

The divider has two states, LOW and HIGH. It alternates between them at the lengths taken from a shadow copy of the settings. In pass-through it rests in LOW.

Top module: `sdclk_gen`

## Requirements
- R1: After the synchronous active-high reset, the control word reads 0x0000 and `card_clk` is low.
- R2: The stable flag (bit 1) rises exactly `STABLE_CYCLES` base cycles after the write that sets the internal-clock enable (bit 0).
- R3: Clearing bit 0 clears the stable flag in the cycle after the write, and card clock pulses stop.
- R4: `card_clk` stays low while the card enable (bit 2) is 0, and while the stable flag is 0 even if bit 2 is set.
- R5: With bit 5 clear and `N > 0`, the card clock is high for `N` and low for `N` base cycles.
- R6: With bit 5 clear and `N = 0`, the card clock follows the base clock.
- R7: With bit 5 set, the card clock period is `N + 1` multiplied-clock cycles. The high phase is `ceil((N+1)/2)` cycles, which makes it one cycle longer than the low phase when `N + 1` is odd.
- R8: With bit 5 set and `N = 0`, the card clock follows the multiplied clock.
- R9: `N[7:0]` sits in bits 15:8 and `N[9:8]` sits in bits 7:6. Bits 15:5 and bit 2 read back as written; bits 4:3 read 0.
- R10: A new `N` written while running takes effect at a low phase. No high pulse is shorter than the shorter of the old and new high phases.
- R11: A law change written while running is deferred. The source and law switch only after the card clock has been disabled and the gate has closed.
- R12: Bit 1 ignores writes; writing 1 to it with bit 0 clear leaves the word at 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_base | input | 1 | Fast base clock, also the register clock |
| clk_mult | input | 1 | Multiplied clock used by the integer law |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 16 | Control word write data |
| ctl_rdata | output | 16 | Control word read data, including the stable flag |
| card_clk | output | 1 | Gated card clock |

## Verification
On every base cycle the assertions check several things:
- the stable flag against an independent count of enabled cycles;
- the readback of every writable field one cycle after a write;
- that the stable flag drops in the cycle after the enable is cleared;
- that the source select never moves while the gate enable is asserted.

Only the bench scenarios can show the card clock's actual high and low durations under each law. This covers pass-through, odd integer divisors and the widest divisors. The same is true of the absence of runt pulses across a live divisor change and the deferral of a law change until the clock is re-enabled.

// File: rtl/sdclk_pkg.sv
`timescale 1ns/1ps
package sdclk_pkg;

    localparam int DIVW = 10;
    localparam int LENW = DIVW + 1;

    localparam int F_ICE   = 0;
    localparam int F_STB   = 1;
    localparam int F_CCE   = 2;
    localparam int F_PROG  = 5;
    localparam int F_NHI   = 6;
    localparam int F_NLO   = 8;

    typedef enum logic [1:0] {
        SEQ_OFF,
        SEQ_WARM,
        SEQ_READY,
        SEQ_RUN
    } seq_state_t;

    typedef enum logic {
        DIV_LO,
        DIV_HI
    } div_state_t;

    typedef struct packed {
        logic            bypass;
        logic [LENW-1:0] hi_len;
        logic [LENW-1:0] lo_len;
    } div_cfg_t;

    function automatic div_cfg_t calc_cfg(input logic prog, input logic [DIVW-1:0] n);
        logic [LENW-1:0] d;
        div_cfg_t        c;
        d        = prog ? (LENW'(n) + LENW'(1)) : {n, 1'b0};
        c.bypass = (d <= LENW'(1));
        c.hi_len = (d + LENW'(1)) >> 1;
        c.lo_len = d >> 1;
        return c;
    endfunction

endpackage

// File: rtl/sdclk_ctl_reg.sv
`timescale 1ns/1ps
module sdclk_ctl_reg
    import sdclk_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr,
    input  logic            wr_ice,
    input  logic            wr_cce,
    input  logic            wr_prog,
    input  logic [DIVW-1:0] wr_n,
    input  logic            stable,
    output logic            ice,
    output logic            cce,
    output logic            prog_req,
    output logic [DIVW-1:0] n,
    output logic [15:0]     rdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ice      <= 1'b0;
            cce      <= 1'b0;
            prog_req <= 1'b0;
            n        <= '0;
        end else if (wr) begin
            ice      <= wr_ice;
            cce      <= wr_cce;
            prog_req <= wr_prog;
            n        <= wr_n;
        end
    end

    always_comb begin
        rdata              = '0;
        rdata[F_ICE]       = ice;
        rdata[F_STB]       = stable;
        rdata[F_CCE]       = cce;
        rdata[F_PROG]      = prog_req;
        rdata[F_NHI +: 2]  = n[DIVW-1 -: 2];
        rdata[F_NLO +: 8]  = n[7:0];
    end

endmodule

// File: rtl/sdclk_seq.sv
`timescale 1ns/1ps
module sdclk_seq
    import sdclk_pkg::*;
#(
    parameter int STABLE_CYCLES = 16,
    parameter int SWITCH_QUIET  = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic ice,
    input  logic cce,
    input  logic prog_req,
    input  logic gate_open,
    output logic stable,
    output logic run_en,
    output logic src_sel
);

    localparam int WCW = $clog2(STABLE_CYCLES + 1);
    localparam int QCW = $clog2(SWITCH_QUIET + 1);
    localparam logic [WCW-1:0] WARM_LAST = WCW'(STABLE_CYCLES - 1);
    localparam logic [QCW-1:0] QUIET_MAX = QCW'(SWITCH_QUIET);

    seq_state_t      state, nxt;
    logic [WCW-1:0]  wcnt;
    logic [QCW-1:0]  quiet;
    logic            gate_meta, gate_sync;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= SEQ_OFF;
        else     state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            SEQ_OFF:   if (ice) nxt = SEQ_WARM;
            SEQ_WARM:  if (!ice) nxt = SEQ_OFF;
                       else if (wcnt == WARM_LAST) nxt = SEQ_READY;
            SEQ_READY: if (!ice) nxt = SEQ_OFF;
                       else if (cce && (src_sel == prog_req)) nxt = SEQ_RUN;
            SEQ_RUN:   if (!ice) nxt = SEQ_OFF;
                       else if (!cce) nxt = SEQ_READY;
            default:   nxt = SEQ_OFF;
        endcase
    end

    // outputs
    always_comb begin
        stable = ((state == SEQ_READY) || (state == SEQ_RUN)) && ice;
        run_en = (state == SEQ_RUN) && ice && cce;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wcnt      <= WCW'(1);
            quiet     <= '0;
            gate_meta <= 1'b0;
            gate_sync <= 1'b0;
            src_sel   <= 1'b0;
        end else begin
            gate_meta <= gate_open;
            gate_sync <= gate_meta;
            if (state != SEQ_WARM) wcnt <= WCW'(1);
            else                   wcnt <= wcnt + WCW'(1);
            if (run_en)                 quiet <= '0;
            else if (quiet != QUIET_MAX) quiet <= quiet + QCW'(1);
            if ((state != SEQ_RUN) && (quiet == QUIET_MAX) && !gate_sync)
                src_sel <= prog_req;
        end
    end

endmodule

// File: rtl/sdclk_div.sv
`timescale 1ns/1ps
module sdclk_div
    import sdclk_pkg::*;
(
    input  logic            src_clk,
    input  logic            rst,
    input  logic            prog,
    input  logic [DIVW-1:0] n,
    output logic            raw
);

    div_cfg_t        sh;
    div_state_t      state, nxt;
    logic [LENW-1:0] cnt, cnt_nxt;

    // shadow settings are taken only while the output rests low
    always_ff @(negedge src_clk) begin
        if (rst)                   sh <= calc_cfg(1'b1, '0);
        else if (state == DIV_LO)  sh <= calc_cfg(prog, n);
    end

    // state register
    always_ff @(posedge src_clk) begin
        if (rst) begin
            state <= DIV_LO;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        nxt     = state;
        cnt_nxt = cnt + LENW'(1);
        if (sh.bypass) begin
            nxt     = DIV_LO;
            cnt_nxt = '0;
        end else begin
            unique case (state)
                DIV_LO: if (cnt >= sh.lo_len - LENW'(1)) begin
                            nxt     = DIV_HI;
                            cnt_nxt = '0;
                        end
                DIV_HI: if (cnt >= sh.hi_len - LENW'(1)) begin
                            nxt     = DIV_LO;
                            cnt_nxt = '0;
                        end
                default: begin
                            nxt     = DIV_LO;
                            cnt_nxt = '0;
                        end
            endcase
        end
    end

    // output
    always_comb begin
        raw = sh.bypass ? src_clk : (state == DIV_HI);
    end

endmodule

// File: rtl/sdclk_gate.sv
`timescale 1ns/1ps
module sdclk_gate (
    input  logic rst,
    input  logic raw,
    input  logic en,
    output logic gate_q,
    output logic card_clk
);

    always_latch begin
        if (rst)       gate_q = 1'b0;
        else if (!raw) gate_q = en;
    end

    assign card_clk = raw & gate_q;

endmodule

// File: rtl/sdclk_gen.sv
`timescale 1ns/1ps
module sdclk_gen
    import sdclk_pkg::*;
#(
    parameter int STABLE_CYCLES = 16,
    parameter int SWITCH_QUIET  = 3
) (
    input  logic        clk_base,
    input  logic        clk_mult,
    input  logic        rst,
    input  logic        ctl_wr,
    input  logic [15:0] ctl_wdata,
    output logic [15:0] ctl_rdata,
    output logic        card_clk
);

    logic            ice, cce, prog_req, stable, run_en, src_sel;
    logic            src_clk, raw, gate_q;
    logic [DIVW-1:0] n;

    sdclk_ctl_reg u_reg (
        .clk      (clk_base),
        .rst      (rst),
        .wr       (ctl_wr),
        .wr_ice   (ctl_wdata[F_ICE]),
        .wr_cce   (ctl_wdata[F_CCE]),
        .wr_prog  (ctl_wdata[F_PROG]),
        .wr_n     ({ctl_wdata[F_NHI +: 2], ctl_wdata[F_NLO +: 8]}),
        .stable   (stable),
        .ice      (ice),
        .cce      (cce),
        .prog_req (prog_req),
        .n        (n),
        .rdata    (ctl_rdata)
    );

    sdclk_seq #(
        .STABLE_CYCLES (STABLE_CYCLES),
        .SWITCH_QUIET  (SWITCH_QUIET)
    ) u_seq (
        .clk       (clk_base),
        .rst       (rst),
        .ice       (ice),
        .cce       (cce),
        .prog_req  (prog_req),
        .gate_open (gate_q),
        .stable    (stable),
        .run_en    (run_en),
        .src_sel   (src_sel)
    );

    assign src_clk = src_sel ? clk_mult : clk_base;

    sdclk_div u_div (
        .src_clk (src_clk),
        .rst     (rst),
        .prog    (src_sel),
        .n       (n),
        .raw     (raw)
    );

    sdclk_gate u_gate (
        .rst      (rst),
        .raw      (raw),
        .en       (run_en),
        .gate_q   (gate_q),
        .card_clk (card_clk)
    );

endmodule

// File: rtl/sdclk_gen_chk.sv
`timescale 1ns/1ps
module sdclk_gen_chk #(
    parameter int STABLE_CYCLES = 16
) (
    input logic        clk,
    input logic        rst,
    input logic        ctl_wr,
    input logic [15:0] ctl_wdata,
    input logic [15:0] ctl_rdata,
    input logic        run_en,
    input logic        src_sel
);

    localparam int CW = $clog2(STABLE_CYCLES + 1);
    logic [CW-1:0] on_cnt;

    always_ff @(posedge clk) begin
        if (rst || !ctl_rdata[0])               on_cnt <= '0;
        else if (on_cnt != CW'(STABLE_CYCLES))  on_cnt <= on_cnt + CW'(1);
    end

    // R2
    stable_delay_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_rdata[0] |-> (ctl_rdata[1] == (on_cnt == CW'(STABLE_CYCLES))));

    // R3
    stable_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && !ctl_wdata[0]) |=> !ctl_rdata[1]);

    // R9
    field_readback_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_wr |=> (ctl_rdata[15:2] == ($past(ctl_wdata[15:2]) & 14'b11111111111001)));

    // R11
    src_hold_chk: assert property (@(posedge clk) disable iff (rst)
        run_en |-> $stable(src_sel));

    // R12
    stable_ro_chk: assert property (@(posedge clk) disable iff (rst)
        !ctl_rdata[0] |-> !ctl_rdata[1]);

endmodule

bind sdclk_gen sdclk_gen_chk #(.STABLE_CYCLES(STABLE_CYCLES)) u_chk (
    .clk       (clk_base),
    .rst       (rst),
    .ctl_wr    (ctl_wr),
    .ctl_wdata (ctl_wdata),
    .ctl_rdata (ctl_rdata),
    .run_en    (run_en),
    .src_sel   (src_sel)
);

// File: tb/sim_sdclk_gen.sv
`timescale 1ns/1ps
module sim_sdclk_gen;

    localparam int S = 16;

    typedef struct packed {
        logic       prog;
        logic [9:0] n;
        int         hi_ns;
        int         lo_ns;
    } vec_t;

    // base clock 8 ns, multiplied clock 6 ns
    localparam vec_t VECS [9] = '{
        '{1'b0, 10'd1,    8,    8},
        '{1'b0, 10'd3,   24,   24},
        '{1'b0, 10'd0,    4,    4},
        '{1'b0, 10'd256, 2048, 2048},
        '{1'b1, 10'd0,    3,    3},
        '{1'b1, 10'd1,    6,    6},
        '{1'b1, 10'd2,   12,    6},
        '{1'b1, 10'd4,   18,   12},
        '{1'b1, 10'd1023, 3072, 3072}
    };

    logic        clk_base = 1'b0;
    logic        clk_mult = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_wr = 1'b0;
    logic [15:0] ctl_wdata = '0;
    logic [15:0] ctl_rdata;
    logic        card_clk;

    int     checks = 0;
    int     failures = 0;
    int     pulses = 0;
    longint t_rise = 0;
    longint min_hi = 64'd1000000000;
    bit     done = 1'b0;

    always #4 clk_base = ~clk_base;
    always #3 clk_mult = ~clk_mult;

    sdclk_gen #(.STABLE_CYCLES(S)) u0 (
        .clk_base  (clk_base),
        .clk_mult  (clk_mult),
        .rst       (rst),
        .ctl_wr    (ctl_wr),
        .ctl_wdata (ctl_wdata),
        .ctl_rdata (ctl_rdata),
        .card_clk  (card_clk)
    );

    always @(posedge card_clk) begin
        pulses = pulses + 1;
        t_rise = $time;
    end

    always @(negedge card_clk) begin
        if (($time - t_rise) < min_hi) min_hi = $time - t_rise;
    end

    function automatic logic [15:0] mkctl(logic ice, logic cce, logic prog, logic [9:0] n);
        return {n[7:0], n[9:8], prog, 2'b00, cce, 1'b0, ice};
    endfunction

    function automatic string req_of(vec_t v);
        if (v.prog)            return (v.n == 0) ? "R8" : "R7";
        else if (v.n == 0)     return "R6";
        else if (v.n > 255)    return "R9";
        else                   return "R5";
    endfunction

    task automatic chk(string req, string what, longint act, longint exp);
        checks = checks + 1;
        if (act != exp) begin
            failures = failures + 1;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [15:0] d);
        @(negedge clk_base);
        ctl_wr    = 1'b1;
        ctl_wdata = d;
        @(negedge clk_base);
        ctl_wr    = 1'b0;
    endtask

    task automatic cycles(int k);
        repeat (k) @(negedge clk_base);
    endtask

    task automatic measure(string req, longint ehi, longint elo);
        longint t0, t1, t2;
        repeat (3) @(posedge card_clk);
        @(posedge card_clk); t0 = $time;
        @(negedge card_clk); t1 = $time;
        @(posedge card_clk); t2 = $time;
        chk(req, "high ns", t1 - t0, ehi);
        chk(req, "low ns",  t2 - t1, elo);
    endtask

    task automatic quiet_window(string req, int k);
        int p0;
        p0 = pulses;
        cycles(k);
        chk(req, "pulses while gated", pulses - p0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk_base);
        if (!done) begin
            failures = failures + 1;
            $display("FAIL watchdog all requirements actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        cycles(10);
        rst = 1'b0;
        cycles(2);

        // R1 reset state
        chk("R1", "rdata", ctl_rdata, 16'h0000);
        chk("R1", "card_clk", card_clk, 0);

        // R12 stable bit ignores writes
        wr(16'h0002);
        chk("R12", "rdata", ctl_rdata, 16'h0000);

        // R2 stable delay
        wr(mkctl(1'b1, 1'b0, 1'b0, 10'd1));
        cycles(S - 1);
        chk("R2", "stable one cycle early", ctl_rdata[1], 0);
        cycles(1);
        chk("R2", "stable on time", ctl_rdata[1], 1);

        // table of modes and divisors
        for (int i = 0; i < 9; i++) begin
            wr(mkctl(1'b1, 1'b0, VECS[i].prog, VECS[i].n));
            cycles(20);
            wr(mkctl(1'b1, 1'b1, VECS[i].prog, VECS[i].n));
            measure(req_of(VECS[i]), VECS[i].hi_ns, VECS[i].lo_ns);
        end

        // R4 card enable clear holds output low
        wr(mkctl(1'b1, 1'b0, 1'b0, 10'd1));
        cycles(8);
        quiet_window("R4", 60);

        // R9 field split readback
        wr(mkctl(1'b1, 1'b0, 1'b0, 10'd256));
        chk("R9", "rdata n=256", ctl_rdata, 16'h0043);
        wr(mkctl(1'b1, 1'b0, 1'b1, 10'h2A5));
        chk("R9", "rdata n=0x2A5", ctl_rdata, 16'hA5A3);

        // R10 live divisor change
        wr(mkctl(1'b1, 1'b0, 1'b0, 10'd4));
        cycles(20);
        wr(mkctl(1'b1, 1'b1, 1'b0, 10'd4));
        measure("R10", 32, 32);
        min_hi = 64'd1000000000;
        wr(mkctl(1'b1, 1'b1, 1'b0, 10'd1));
        measure("R10", 8, 8);
        chk("R10", "no runt high", (min_hi >= 8) ? 1 : 0, 1);

        // R11 law change deferred while running
        wr(mkctl(1'b1, 1'b1, 1'b0, 10'd2));
        measure("R11", 16, 16);
        wr(mkctl(1'b1, 1'b1, 1'b1, 10'd2));
        measure("R11", 16, 16);
        wr(mkctl(1'b1, 1'b0, 1'b1, 10'd2));
        cycles(20);
        wr(mkctl(1'b1, 1'b1, 1'b1, 10'd2));
        measure("R11", 12, 6);

        // R3 internal enable clear
        wr(mkctl(1'b0, 1'b1, 1'b1, 10'd2));
        chk("R3", "stable after clear", ctl_rdata[1], 0);
        cycles(4);
        quiet_window("R3", 40);

        // R4 card enable before stable
        wr(mkctl(1'b1, 1'b1, 1'b0, 10'd1));
        quiet_window("R4", S - 3);
        measure("R4", 8, 8);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule